// File: doc/BRIEF.md
# Karatsuba Carry-Less Polynomial Multiplier (256 x 256)

This block multiplies two binary polynomials of 4·CORE_W bits each (256 bits with the default CORE_W of 64) without carries, i.e. over GF(2), and returns the full double-width product as four limbs of 2·CORE_W bits. Each operand enters as a low and a high limb. The product is built by Karatsuba splitting applied twice. At the top level there are three half-width products: low by low, high by high, and the XOR of the halves by the XOR of the halves. Each of those is split again the same way. The result is nine CORE_W x CORE_W carry-less leaf products.

The parameter PARALLEL picks the datapath variant. With PARALLEL = 0, one combinational leaf multiplier is time-shared over nine cycles and the leaf products are held in registers. With PARALLEL = 1, nine leaf multipliers work side by side. A caller pulses `start` while `busy` is low and waits for the one-cycle `done` pulse. The product stays on the outputs until a later request completes. Reduction modulo a field polynomial is left to the consumer.

Top module: `kara_clmul256`

## Requirements
- R1: {prod3, prod2, prod1, prod0} (prod0 holds bits 0 upward) equals the carry-less product of A = {a_hi, a_lo} and B = {b_hi, b_lo}.
- R2: If either operand is zero, all four product limbs are zero.
- R3: With A equal to one (a_lo = 1, a_hi = 0), {prod1, prod0} equals B and prod3 and prod2 are zero.
- R4: The most significant bit of prod3 is always zero, because the product degree is at most 8·CORE_W−2. This includes all-ones by all-ones.
- R5: `done` is high for exactly one cycle per accepted request, and never while `busy` is high.
- R6: A `start` pulse while `busy` is high is ignored. It produces no extra `done`, and the result belongs to the request that was accepted.
- R7: The product limbs keep their value in every cycle in which `done` is low, even if the operand inputs change.
- R8: After reset `done` and `busy` are low and all product limbs are zero.
- R9: `done` rises exactly LATENCY cycles after the clock edge that accepts `start`. LATENCY is 10 when PARALLEL = 0 (nine leaf cycles plus one combine cycle) and 1 when PARALLEL = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted only while busy is low |
| a_lo | input | 2·CORE_W | Operand A, low limb |
| a_hi | input | 2·CORE_W | Operand A, high limb |
| b_lo | input | 2·CORE_W | Operand B, low limb |
| b_hi | input | 2·CORE_W | Operand B, high limb |
| busy | output | 1 | A request is being computed |
| prod0 | output | 2·CORE_W | Product bits 2·CORE_W−1..0 |
| prod1 | output | 2·CORE_W | Product limb 1 |
| prod2 | output | 2·CORE_W | Product limb 2 |
| prod3 | output | 2·CORE_W | Product limb 3, most significant |
| done | output | 1 | One-cycle pulse: product limbs are valid |

## Verification
The bench runs two configurations. The first is the default 256-bit time-shared multiplier, driven with zero, one, all-ones, single-bit and random operands. The second is a 16-bit parallel instance, swept over a dense grid of operand pairs. Both are compared against a bit-serial shift-and-XOR product. All-ones operands light every cross term, so a middle term that misses one of its XOR corrections, or is placed at the wrong offset, corrupts the inner limbs. Single-bit and unit operands show a wrong leaf index or swapped limbs as a shifted copy of the other operand. A second start while busy, and operand changes after done, show a controller that re-accepts early or lets its outputs follow the inputs.

// File: rtl/kara_clmul_pkg.sv
package kara_clmul_pkg;
   // three sub-products per Karatsuba level, two levels deep
   localparam int unsigned SPLIT  = 3;
   localparam int unsigned LEAVES = SPLIT * SPLIT;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_RUN,
      PH_FIN
   } phase_t;
endpackage

// File: rtl/kara_clmul_core.sv
module kara_clmul_core #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   output logic [2*W-1:0] p
);
   localparam int unsigned PW = 2 * W;

   logic [W-1:0][PW-1:0] rows;

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_row
         assign rows[i] = y[i] ? (PW'(x) << i) : '0;
      end
   endgenerate

   always_comb begin
      p = '0;
      for (int k = 0; k < W; k++) p = p ^ rows[k];
   end
endmodule

// File: rtl/kara_merge.sv
module kara_merge #(
   parameter int unsigned HW = 64
) (
   input  logic [2*HW-1:0] lo_p,
   input  logic [2*HW-1:0] hi_p,
   input  logic [2*HW-1:0] cross_p,
   output logic [4*HW-1:0] full
);
   logic [2*HW-1:0] mid;

   // cross product minus (XOR) the two outer products leaves the middle term
   assign mid  = cross_p ^ lo_p ^ hi_p;
   // middle term sits HW bits up, straddling the lo/hi boundary
   assign full = {hi_p, lo_p} ^ {{HW{1'b0}}, mid, {HW{1'b0}}};
endmodule

// File: rtl/kara_split.sv
module kara_split
   import kara_clmul_pkg::*;
#(
   parameter int unsigned W = 64
) (
   input  logic [2*W-1:0]             a_lo,
   input  logic [2*W-1:0]             a_hi,
   input  logic [2*W-1:0]             b_lo,
   input  logic [2*W-1:0]             b_hi,
   output logic [LEAVES-1:0][W-1:0]   lx,
   output logic [LEAVES-1:0][W-1:0]   ly
);
   logic [SPLIT-1:0][2*W-1:0] tx;
   logic [SPLIT-1:0][2*W-1:0] ty;

   assign tx[0] = a_lo;
   assign tx[1] = a_hi;
   assign tx[2] = a_lo ^ a_hi;
   assign ty[0] = b_lo;
   assign ty[1] = b_hi;
   assign ty[2] = b_lo ^ b_hi;

   genvar i, j;
   generate
      for (i = 0; i < SPLIT; i++) begin : g_top
         for (j = 0; j < SPLIT; j++) begin : g_inner
            if (j == 0) begin : g_low
               assign lx[i*SPLIT+j] = tx[i][W-1:0];
               assign ly[i*SPLIT+j] = ty[i][W-1:0];
            end else if (j == 1) begin : g_high
               assign lx[i*SPLIT+j] = tx[i][2*W-1:W];
               assign ly[i*SPLIT+j] = ty[i][2*W-1:W];
            end else begin : g_fold
               assign lx[i*SPLIT+j] = tx[i][W-1:0] ^ tx[i][2*W-1:W];
               assign ly[i*SPLIT+j] = ty[i][W-1:0] ^ ty[i][2*W-1:W];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/kara_tree.sv
module kara_tree
   import kara_clmul_pkg::*;
#(
   parameter int unsigned W = 64
) (
   input  logic [LEAVES-1:0][2*W-1:0] leaf_p,
   output logic [8*W-1:0]             full
);
   logic [SPLIT-1:0][4*W-1:0] part;

   genvar i;
   generate
      for (i = 0; i < SPLIT; i++) begin : g_inner
         kara_merge #(.HW(W)) u_merge (
            .lo_p    (leaf_p[i*SPLIT]),
            .hi_p    (leaf_p[i*SPLIT+1]),
            .cross_p (leaf_p[i*SPLIT+2]),
            .full    (part[i])
         );
      end
   endgenerate

   kara_merge #(.HW(2*W)) u_outer (
      .lo_p    (part[0]),
      .hi_p    (part[1]),
      .cross_p (part[2]),
      .full    (full)
   );
endmodule

// File: rtl/kara_clmul256.sv
module kara_clmul256
   import kara_clmul_pkg::*;
#(
   parameter int unsigned CORE_W   = 64,
   parameter int unsigned PARALLEL = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [2*CORE_W-1:0]   a_lo,
   input  logic [2*CORE_W-1:0]   a_hi,
   input  logic [2*CORE_W-1:0]   b_lo,
   input  logic [2*CORE_W-1:0]   b_hi,
   output logic                  busy,
   output logic [2*CORE_W-1:0]   prod0,
   output logic [2*CORE_W-1:0]   prod1,
   output logic [2*CORE_W-1:0]   prod2,
   output logic [2*CORE_W-1:0]   prod3,
   output logic                  done
);
   localparam int unsigned LIMB_W  = 2 * CORE_W;
   localparam int unsigned PROD_W  = 8 * CORE_W;
   localparam int unsigned CNT_W   = $clog2(LEAVES);
   localparam int unsigned LATENCY = (PARALLEL != 0) ? 1 : LEAVES + 1;
   localparam int unsigned LAT_W   = $clog2(LATENCY + 3);

   generate
      if (CORE_W < 2) begin : g_bad_width
         $error("CORE_W must be at least 2");
      end
      if (PARALLEL > 1) begin : g_bad_mode
         $error("PARALLEL must be 0 or 1");
      end
   endgenerate

   logic                        accept;
   logic                        busy_int;
   logic                        prod_ready;
   logic [LIMB_W-1:0]           ra_lo, ra_hi, rb_lo, rb_hi;
   logic [LEAVES-1:0][CORE_W-1:0] lx, ly;
   logic [LEAVES-1:0][LIMB_W-1:0] leaf_p;
   logic [PROD_W-1:0]           full_p;
   logic [PROD_W-1:0]           out_q;
   logic                        done_q;

   assign accept = start && !busy_int;

   // operand capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ra_lo <= '0;
         ra_hi <= '0;
         rb_lo <= '0;
         rb_hi <= '0;
      end else if (accept) begin
         ra_lo <= a_lo;
         ra_hi <= a_hi;
         rb_lo <= b_lo;
         rb_hi <= b_hi;
      end
   end

   kara_split #(.W(CORE_W)) u_split (
      .a_lo (ra_lo),
      .a_hi (ra_hi),
      .b_lo (rb_lo),
      .b_hi (rb_hi),
      .lx   (lx),
      .ly   (ly)
   );

   generate
      if (PARALLEL != 0) begin : g_par
         logic run_q;

         for (genvar k = 0; k < LEAVES; k++) begin : g_core
            kara_clmul_core #(.W(CORE_W)) u_core (
               .x (lx[k]),
               .y (ly[k]),
               .p (leaf_p[k])
            );
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) run_q <= 1'b0;
            else        run_q <= accept;
         end

         assign busy_int   = run_q;
         assign prod_ready = run_q;
      end else begin : g_seq
         phase_t                        phase_q;
         logic [CNT_W-1:0]              cnt_q;
         logic [CORE_W-1:0]             core_x, core_y;
         logic [LIMB_W-1:0]             core_p;
         logic [LEAVES-1:0][LIMB_W-1:0] store_q;

         always_comb begin
            core_x = '0;
            core_y = '0;
            for (int k = 0; k < LEAVES; k++) begin
               if (cnt_q == CNT_W'(k)) begin
                  core_x = lx[k];
                  core_y = ly[k];
               end
            end
         end

         kara_clmul_core #(.W(CORE_W)) u_core (
            .x (core_x),
            .y (core_y),
            .p (core_p)
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= PH_IDLE;
               cnt_q   <= '0;
            end else begin
               case (phase_q)
                  PH_IDLE: if (accept) begin
                     phase_q <= PH_RUN;
                     cnt_q   <= '0;
                  end
                  PH_RUN: if (cnt_q == CNT_W'(LEAVES - 1)) begin
                     phase_q <= PH_FIN;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
                  default: phase_q <= PH_IDLE;
               endcase
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               store_q <= '0;
            end else if (phase_q == PH_RUN) begin
               for (int k = 0; k < LEAVES; k++) begin
                  if (cnt_q == CNT_W'(k)) store_q[k] <= core_p;
               end
            end
         end

         assign leaf_p     = store_q;
         assign busy_int   = (phase_q != PH_IDLE);
         assign prod_ready = (phase_q == PH_FIN);

         // R9
         leaf_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (phase_q == PH_RUN) |-> (cnt_q < CNT_W'(LEAVES)));
      end
   endgenerate

   kara_tree #(.W(CORE_W)) u_tree (
      .leaf_p (leaf_p),
      .full   (full_p)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= prod_ready;
         if (prod_ready) out_q <= full_p;
      end
   end

   assign busy  = busy_int;
   assign done  = done_q;
   assign prod0 = out_q[LIMB_W-1:0];
   assign prod1 = out_q[2*LIMB_W-1:LIMB_W];
   assign prod2 = out_q[3*LIMB_W-1:2*LIMB_W];
   assign prod3 = out_q[4*LIMB_W-1:3*LIMB_W];

   // cycles since the accepting edge, used only by the latency check
   logic [LAT_W-1:0] lat_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    lat_cnt <= '0;
      else if (accept)               lat_cnt <= '0;
      else if (busy_int && lat_cnt != '1) lat_cnt <= lat_cnt + 1'b1;
   end

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R5
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_int);

   // R6
   done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(busy_int));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> $stable(out_q));

   // R9
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (lat_cnt == LAT_W'(LATENCY)));

   // R4
   top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_q[PROD_W-1]);
endmodule

// File: tb/tb_kara_clmul256.sv
module tb_kara_clmul256;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // default instance: 256-bit, time-shared core
   logic         start = 1'b0;
   logic [127:0] a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
   logic [127:0] prod0, prod1, prod2, prod3;
   logic         busy, done;

   kara_clmul256 dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
      .busy(busy), .prod0(prod0), .prod1(prod1), .prod2(prod2), .prod3(prod3),
      .done(done)
   );

   // small instance: 16-bit operands, replicated cores
   logic       s_start = 1'b0;
   logic [7:0] s_a_lo = '0, s_a_hi = '0, s_b_lo = '0, s_b_hi = '0;
   logic [7:0] s_p0, s_p1, s_p2, s_p3;
   logic       s_busy, s_done;

   kara_clmul256 #(.CORE_W(4), .PARALLEL(1)) dut_par (
      .clk(clk), .rst_n(rst_n), .start(s_start),
      .a_lo(s_a_lo), .a_hi(s_a_hi), .b_lo(s_b_lo), .b_hi(s_b_hi),
      .busy(s_busy), .prod0(s_p0), .prod1(s_p1), .prod2(s_p2), .prod3(s_p3),
      .done(s_done)
   );

   function automatic logic [511:0] clmul_ref(input logic [255:0] x, input logic [255:0] y);
      logic [511:0] r = '0;
      for (int i = 0; i < 256; i++) if (y[i]) r = r ^ ({256'b0, x} << i);
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic big_op(input logic [255:0] a, input logic [255:0] b, input string req);
      int n;
      logic [511:0] got, expv;
      @(negedge clk);
      a_lo = a[127:0]; a_hi = a[255:128];
      b_lo = b[127:0]; b_hi = b[255:128];
      start = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         n++;
         start = 1'b0;
      end while (!done && n < 60);
      got  = {prod3, prod2, prod1, prod0};
      expv = clmul_ref(a, b);
      chk(n == 11, "R9 latency (negedges to done)", 512'(n), 512'd11);
      chk(got == expv, req, got, expv);
      @(negedge clk);
      chk(!done, "R5 done single cycle", 512'(done), 512'd0);
   endtask

   task automatic small_op(input logic [15:0] a, input logic [15:0] b);
      int n;
      logic [31:0] got, expv;
      logic [511:0] full;
      @(negedge clk);
      s_a_lo = a[7:0]; s_a_hi = a[15:8];
      s_b_lo = b[7:0]; s_b_hi = b[15:8];
      s_start = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         n++;
         s_start = 1'b0;
      end while (!s_done && n < 20);
      full = clmul_ref({240'b0, a}, {240'b0, b});
      expv = full[31:0];
      got  = {s_p3, s_p2, s_p1, s_p0};
      if (n != 2) chk(1'b0, "R9 parallel latency", 512'(n), 512'd2);
      chk(got == expv, "R1 small sweep", 512'(got), 512'(expv));
   endtask

   function automatic logic [255:0] rnd256();
      logic [255:0] v;
      for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [255:0] ra, rb, rc;
      logic [511:0] held;
      int dones;
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(!done && !busy, "R8 done/busy after reset", 512'({done, busy}), 512'd0);
      chk({prod3, prod2, prod1, prod0} == '0, "R8 outputs after reset",
          {prod3, prod2, prod1, prod0}, 512'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !busy && !s_done && !s_busy, "R8 idle after release", 512'({done, busy}), 512'd0);

      // R2 zero operands
      big_op('0, rnd256(), "R2 zero times random");
      big_op(rnd256(), '0, "R2 random times zero");
      chk({prod3, prod2, prod1, prod0} == '0, "R2 zero result", {prod3, prod2, prod1, prod0}, 512'd0);

      // R3 one times B
      rb = rnd256();
      big_op(256'd1, rb, "R3 one times random");
      chk({prod1, prod0} == rb && {prod3, prod2} == '0, "R3 identity limbs",
          {prod3, prod2, prod1, prod0}, {256'b0, rb});

      // R4 all ones
      big_op('1, '1, "R4 all-ones product");
      chk(!prod3[127], "R4 top bit clear", 512'(prod3[127]), 512'd0);

      // R1 single-bit operands on limb and half boundaries
      for (int i = 0; i < 256; i += 31) begin
         big_op(256'd1 << i, 256'd1 << (255 - i), "R1 single bits");
      end
      big_op(256'd1 << 255, 256'd1 << 255, "R4 top bits");
      chk(!prod3[127] && prod3[126], "R4 degree 510 term", 512'(prod3[127:126]), 512'd1);

      // R1 random operands
      for (int i = 0; i < 40; i++) big_op(rnd256(), rnd256(), "R1 random");

      // R6 start while busy is ignored
      ra = rnd256(); rb = rnd256(); rc = rnd256();
      @(negedge clk);
      a_lo = ra[127:0]; a_hi = ra[255:128]; b_lo = rb[127:0]; b_hi = rb[255:128];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      a_lo = rc[127:0]; a_hi = rc[255:128]; b_lo = rc[255:128]; b_hi = rc[127:0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      dones = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (done) begin
            dones++;
            held = {prod3, prod2, prod1, prod0};
         end
      end
      chk(dones == 1, "R6 one done for busy restart", 512'(dones), 512'd1);
      chk(held == clmul_ref(ra, rb), "R6 result from accepted request", held, clmul_ref(ra, rb));

      // R7 outputs hold while inputs wander
      held = {prod3, prod2, prod1, prod0};
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         a_lo = rc[127:0] ^ 128'(i); b_hi = ~rc[127:0];
      end
      chk({prod3, prod2, prod1, prod0} == held, "R7 hold without start",
          {prod3, prod2, prod1, prod0}, held);

      // small parallel instance: dense grid sweep, plus corners
      small_op(16'h0000, 16'hFFFF);
      small_op(16'hFFFF, 16'hFFFF);
      small_op(16'h0001, 16'hA5C3);
      for (int ia = 0; ia < 64; ia++) begin
         for (int ib = 0; ib < 64; ib++) begin
            small_op(16'(ia * 1021 + 3), 16'(ib * 997 + 11));
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule